// File: doc/BRIEF.md
# Snapshot-Latched 64-bit Tick Counter

This block counts pulses of a single tick strobe in a 64-bit register that runs freely from reset. Software does not read the live count directly. Three 32-bit registers on a simple register bus are visible instead: a low snapshot word, a high snapshot word and a command/control word. Writing the control word with its latch request bit set copies the whole live count into the two snapshot words in one clock, so the two halves always belong to the same instant. Writing the clear request bit zeroes both snapshot words.

Both request bits act once and are never stored. A read of the control word shows them as zero, and the other control bits read back as written. When one write sets both bits, the latch is done first and the clear then overrides it, so both words end at zero. The snapshot words can also be loaded directly by bus writes. None of these register operations change the live count.

The bus is a single-cycle write strobe with address and data. Read data follows the address combinationally.

Top module: `free_count_snapshot`

## Requirements
- R1: After reset the low snapshot (offset 0xA0), the high snapshot (offset 0xA4) and the control word (offset 0xA8) all read as zero.
- R2: A bus write to offset 0xA0 or 0xA4 loads that snapshot word with the written data, and a later read returns it.
- R3: A control write with bit 1 set (latch) and bit 0 clear puts the live count into the snapshot words: bits 31:0 in the low word and bits 63:32 in the high word. The value copied is the count that was present in the cycle of the write, before any tick in that same cycle is added.
- R4: A control write with bit 0 set (clear) and bit 1 clear makes both snapshot words zero.
- R5: A control write with both bit 0 and bit 1 set leaves both snapshot words zero.
- R6: A control read returns bits 31:2 as last written and bits 1:0 as zero.
- R7: The live count starts at the parameter RESET_COUNT (default 0) and rises by one at every clock edge where tick is high. It wraps modulo 2^64 and carries from bit 31 into bit 32.
- R8: A clear request has no effect on the live count.
- R9: Writes to any address other than the three offsets change no register and do not disturb the count. Reads of such addresses return zero.
- R10: Direct writes to the snapshot words have no effect on the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one increment per high cycle |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
A wrong live count stays hidden until the next latch request. It then appears in both snapshot words on the first read after the latch edge, so every check pairs a latch with a read of both words. The bench starts the count close to 2^64 so that a carry error between the two halves appears within a few dozen ticks. A request bit that is wrongly stored shows up at once in a control readback. A clear or latch that is applied in the wrong order leaves a nonzero snapshot on the next read.

// File: rtl/free_count_snapshot.sv
module free_count_snapshot #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [63:0] RESET_COUNT = 64'd0,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'hA0,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'hA4,
  parameter logic [ADDR_W-1:0] CTL_OFS = 8'hA8,
  parameter int unsigned CLR_BIT = 0,
  parameter int unsigned LAT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [31:0] REQ_MASK = (32'd1 << CLR_BIT) | (32'd1 << LAT_BIT);

  logic [63:0] cnt;
  logic [31:0] snap_lo, snap_hi, ctl;

  wire wr_lo  = bus_we && (bus_addr == LO_OFS);
  wire wr_hi  = bus_we && (bus_addr == HI_OFS);
  wire wr_ctl = bus_we && (bus_addr == CTL_OFS);
  wire req_lat = wr_ctl && bus_wdata[LAT_BIT];
  wire req_clr = wr_ctl && bus_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= RESET_COUNT;
      snap_lo <= '0;
      snap_hi <= '0;
      ctl     <= '0;
    end else begin
      if (tick) cnt <= cnt + 64'd1;
      if (wr_lo) snap_lo <= bus_wdata;
      if (wr_hi) snap_hi <= bus_wdata;
      if (wr_ctl) ctl <= bus_wdata & ~REQ_MASK;
      if (req_lat) {snap_hi, snap_lo} <= cnt;
      if (req_clr) begin
        snap_lo <= '0;
        snap_hi <= '0;
      end
    end
  end

  always_comb begin
    if (bus_addr == LO_OFS)       bus_rdata = snap_lo;
    else if (bus_addr == HI_OFS)  bus_rdata = snap_hi;
    else if (bus_addr == CTL_OFS) bus_rdata = ctl;
    else                          bus_rdata = '0;
  end

  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_lat && !req_clr) |=> ({snap_hi, snap_lo} == $past(cnt)));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> (snap_lo == 32'd0 && snap_hi == 32'd0));

  p_req_not_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl[LAT_BIT] == 1'b0 && ctl[CLR_BIT] == 1'b0));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 64'd1));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: tb/free_count_snapshot_tb_top.sv
module free_count_snapshot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] START = 64'hFFFF_FFFF_FFFF_FFF0;

  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [63:0] exp_cnt, pre;
  logic [31:0] r;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  free_count_snapshot #(.RESET_COUNT(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always @(posedge clk)
    if (!rst_n) exp_cnt <= START;
    else if (tick) exp_cnt <= exp_cnt + 64'd1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic tk);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; tick = tk;
    pre = exp_cnt;
    @(negedge clk);
    bus_we = 0; tick = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic run(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ((i + pat) % 3) != 1;
    end
    @(negedge clk);
    tick = 0;
  endtask

  task automatic latch_check(string req, logic tk);
    logic [31:0] v;
    wr(8'hA8, 32'h2, tk);
    rd(8'hA0, v); chk(req, v, pre[31:0]);
    rd(8'hA4, v); chk(req, v, pre[63:32]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(8'hA0, r); chk("R1 lo", r, 0);
    rd(8'hA4, r); chk("R1 hi", r, 0);
    rd(8'hA8, r); chk("R1 ctl", r, 0);
    // R3/R7 latch sweep across the 64-bit wrap and the word carry
    for (int k = 0; k < 40; k++) begin
      run(k, k);
      latch_check("R3/R7 latch", k[0]);
    end
    // R6 control readback
    for (int v = 0; v < 16; v++) begin
      logic [31:0] d;
      d = {v[3:0], 24'h5A5A5A, v[3:0]};
      wr(8'hA8, d, v[0]);
      rd(8'hA8, r); chk("R6 ctl", r, d & ~32'h3);
    end
    // R2 direct write, R10 counter untouched
    wr(8'hA0, 32'h1234_5678, 1);
    wr(8'hA4, 32'h9ABC_DEF0, 0);
    rd(8'hA0, r); chk("R2 lo", r, 32'h1234_5678);
    rd(8'hA4, r); chk("R2 hi", r, 32'h9ABC_DEF0);
    latch_check("R10 count after direct writes", 1);
    // R4 clear, R8 counter continues
    run(5, 0);
    wr(8'hA8, 32'h1, 1);
    rd(8'hA0, r); chk("R4 lo", r, 0);
    rd(8'hA4, r); chk("R4 hi", r, 0);
    rd(8'hA8, r); chk("R4 ctl", r, 0);
    run(7, 2);
    latch_check("R8 count after clear", 0);
    // R5 both requests
    run(3, 1);
    wr(8'hA8, 32'hF0F3, 1);
    rd(8'hA0, r); chk("R5 lo", r, 0);
    rd(8'hA4, r); chk("R5 hi", r, 0);
    rd(8'hA8, r); chk("R5 ctl", r, 32'hF0F0);
    // R9 unmapped addresses
    wr(8'hA0, 32'hCAFE_0001, 0);
    wr(8'hA4, 32'hCAFE_0002, 0);
    wr(8'hA8, 32'h0000_0100, 0);
    for (int a = 0; a < 256; a += 4) begin
      logic [7:0] ad;
      ad = 8'(a + 1);
      wr(ad, 32'hFFFF_FFFF, 1);
    end
    wr(8'hAC, 32'hFFFF_FFFF, 1);
    wr(8'h00, 32'hFFFF_FFFF, 0);
    rd(8'hA0, r); chk("R9 lo kept", r, 32'hCAFE_0001);
    rd(8'hA4, r); chk("R9 hi kept", r, 32'hCAFE_0002);
    rd(8'hA8, r); chk("R9 ctl kept", r, 32'h0000_0100);
    rd(8'hAC, r); chk("R9 read 0xAC", r, 0);
    rd(8'hA1, r); chk("R9 read 0xA1", r, 0);
    rd(8'h00, r); chk("R9 read 0x00", r, 0);
    latch_check("R9 count after stray writes", 1);
    finish_run();
  end
endmodule